// File: doc/BRIEF.md
# Coded I2C/SPI pass-through master

This block is a serial master that works through a short list of slots and turns each one into bus activity, either on an open-drain I2C pair or on a four-wire SPI link. Every slot carries a 4-bit leading code, one data byte and a 4-bit trailing code. The leading code selects the framing that comes before the byte: a start condition, a stop condition, a chip-select release, no framing, or skipping the slot. The trailing code selects how the byte ends: master acknowledge or not-acknowledge, an optional stop condition, or the chip-select level after the byte.

The host loads all slots at once and pulses `start_i`. It also selects the bus with `mode_spi_i`. The block then processes the slots in index order. As each slot completes, the block writes a readback copy of it. The readback holds the byte that was actually seen on the bus and status codes that describe what the bus did. `done_o` pulses once after the last slot. SCL and SDA are modelled as pull-low enables: 1 means the line is driven low, and 0 means it is released. Each SCL low phase and each SCL high phase lasts `HALF` clocks, and every SCK half period lasts the same.

Top module: `cmd_serial_master`

## Requirements
- R1: Slot layout is bits [15:12] leading code, [11:4] data byte and [3:0] trailing code, with slot k at bits [16k+15:16k] of `slot_wr_i` and `slot_rd_o`. In I2C mode, leading code 0110 emits three `HALF`-clock steps before the byte (SCL low with SDA released, then both released, then SDA low with SCL released). Leading code 0001 emits three steps (SCL and SDA low, then SCL released, then SDA released). Any other code except 0111 adds no framing.
- R2: In I2C mode the byte is sent MSB first as eight bits followed by a ninth acknowledge bit. Each bit holds SCL low for `HALF` clocks and then releases SCL for `HALF` clocks. The SDA enable stays constant across each bit. SDA is sampled in the last clock of each high phase.
- R3: In I2C mode, trailing code 0000 drives SDA low in the ninth bit. Any other trailing code releases SDA in the ninth bit. Code 1001 is then followed by the three-step stop sequence of R1.
- R4: In I2C mode the readback leading field is 0110 after a start, 0001 after a leading stop, and otherwise 0000 or 0111 according to whether SDA read low or high in the slot's first cycle. The readback data field is the byte sampled from SDA.
- R5: In I2C mode the readback trailing field is 0000 for trailing code 0000. For code 1001 it is 0001 if the acknowledge bit read low and 1001 if it read high. For any other code it is 0111 if the acknowledge bit read low and 1111 if it read high.
- R6: In SPI mode, leading code 1001 first drives CS high with SCK low for `HALF` clocks. The byte then goes out in mode 0 with CS low, MSB first. Each bit holds SCK low for `HALF` clocks and then high for `HALF` clocks, and MISO is sampled in the last high clock.
- R7: In SPI mode every byte is followed by a `HALF`-clock step with SCK low. CS is high in that step when the trailing code is 1001 and low for any other code.
- R8: In SPI mode the readback is leading field 0111, the MISO byte, and trailing field 1111.
- R9: A slot whose leading code is 0111 (I2C) or 1111 (SPI) causes no bus activity, lasts one clock, and its readback equals the written slot.
- R10: Slots run in index order. `busy_o` is high from the clock after `start_i` is accepted through the `done_o` clock. `done_o` is a single-clock pulse one clock after the last slot ends. `start_i` is ignored while `busy_o` is high.
- R11: After reset the SCL and SDA enables are 0, SCK and MOSI are 0, CS is high, `busy_o` and `done_o` are 0, and `slot_rd_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transaction (sampled when idle) |
| mode_spi_i | input | 1 | 1 selects SPI, 0 selects I2C (latched at start) |
| slot_wr_i | input | NSLOT*16 | Written slots, latched at start |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-clock completion pulse |
| slot_rd_o | output | NSLOT*16 | Readback slots |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| sda_i | input | 1 | SDA line level |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data out |
| csn_o | output | 1 | SPI chip select, active low |
| miso_i | input | 1 | SPI data in |

## Verification
The assertions check properties that hold on every cycle. SDA never moves while SCL is released inside a data bit. SCK is never high while CS is high. `done_o` lasts one clock and only appears while busy. Cycle-exact framing sequences, bit order, the acknowledge level chosen by each trailing code, skipped slots, an ignored mid-transaction start, and the readback codes built from what the bus returned are shown only by the bench's scenarios. Those scenarios compare a behavioural model against the pins on every clock and the readback at completion.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  localparam int SLOT_W = 16;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LOAD, PH_PRE, PH_BIT, PH_POST, PH_FIN
  } phase_e;

  typedef enum logic [1:0] {
    PRE_NONE, PRE_START, PRE_STOP, PRE_DESEL
  } pre_e;

  typedef struct packed {
    logic skip;
    pre_e pre;
    logic post_stop;
    logic ack_drive;
  } act_t;

  localparam logic [3:0] I2C_START = 4'b0110;
  localparam logic [3:0] I2C_STOP  = 4'b0001;
  localparam logic [3:0] I2C_SKIP  = 4'b0111;
  localparam logic [3:0] SPI_DESEL = 4'b1001;
  localparam logic [3:0] SPI_SKIP  = 4'b1111;
  localparam logic [3:0] FIN_MACK  = 4'b0000;
  localparam logic [3:0] FIN_STOP  = 4'b1001;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmd_pkg::*;
(
  input  logic       spi_i,
  input  logic [3:0] icom_i,
  input  logic [3:0] fcom_i,
  output act_t       act_o,
  output logic [1:0] npre_o,
  output logic [4:0] nbit_o,
  output logic [1:0] npost_o
);
  always_comb begin
    act_o           = '0;
    act_o.pre       = PRE_NONE;
    act_o.post_stop = (fcom_i == FIN_STOP);
    if (spi_i) begin
      act_o.skip = (icom_i == SPI_SKIP);
      if (icom_i == SPI_DESEL) act_o.pre = PRE_DESEL;
      npre_o  = (act_o.pre == PRE_DESEL) ? 2'd1 : 2'd0;
      nbit_o  = 5'd16;
      npost_o = 2'd1;
    end else begin
      act_o.skip      = (icom_i == I2C_SKIP);
      act_o.ack_drive = (fcom_i == FIN_MACK);
      if (icom_i == I2C_START)     act_o.pre = PRE_START;
      else if (icom_i == I2C_STOP) act_o.pre = PRE_STOP;
      npre_o  = (act_o.pre != PRE_NONE) ? 2'd3 : 2'd0;
      nbit_o  = 5'd18;
      npost_o = act_o.post_stop ? 2'd3 : 2'd0;
    end
  end
endmodule

// File: rtl/rb_encode.sv
module rb_encode
  import cmd_pkg::*;
(
  input  logic              spi_i,
  input  pre_e              pre_i,
  input  logic [3:0]        fcom_i,
  input  logic              sda_first_i,
  input  logic              ack_low_i,
  input  logic [7:0]        rx_i,
  output logic [SLOT_W-1:0] rd_o
);
  logic [3:0] ini, fin;

  always_comb begin
    if (spi_i) begin
      ini = 4'b0111;
      fin = 4'b1111;
    end else begin
      case (pre_i)
        PRE_START: ini = 4'b0110;
        PRE_STOP:  ini = 4'b0001;
        default:   ini = sda_first_i ? 4'b0111 : 4'b0000;
      endcase
      if (fcom_i == FIN_MACK)      fin = 4'b0000;
      else if (fcom_i == FIN_STOP) fin = ack_low_i ? 4'b0001 : 4'b1001;
      else                         fin = ack_low_i ? 4'b0111 : 4'b1111;
    end
    rd_o = {ini, rx_i, fin};
  end
endmodule

// File: rtl/step_timer.sv
module step_timer #(
  parameter int HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [TW-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == TW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || last_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cmd_serial_master.sv
module cmd_serial_master
  import cmd_pkg::*;
#(
  parameter int NSLOT = 3,
  parameter int HALF  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    mode_spi_i,
  input  logic [NSLOT*SLOT_W-1:0] slot_wr_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [NSLOT*SLOT_W-1:0] slot_rd_o,
  output logic                    scl_oe_o,
  output logic                    sda_oe_o,
  input  logic                    sda_i,
  output logic                    sck_o,
  output logic                    mosi_o,
  output logic                    csn_o,
  input  logic                    miso_i
);
  localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  phase_e ph_q;
  logic [IW-1:0] slot_q;
  logic [4:0] step_q;
  logic spi_q, sda_first_q, ack_low_q;
  logic [7:0] rx_q;
  logic [NSLOT-1:0][SLOT_W-1:0] wr_q, rd_q;
  logic scl_h, sda_h, sck_h, mosi_h, csn_h;

  logic [SLOT_W-1:0] cur, rb;
  act_t act;
  logic [1:0] npre, npost;
  logic [4:0] nbit, step_end;
  logic t_last, hi, cur_bit, in_bit, ack_now, last_slot;
  logic [3:0] bit_idx;

  assign cur       = wr_q[slot_q];
  assign hi        = step_q[0];
  assign bit_idx   = step_q[4:1];
  assign cur_bit   = (bit_idx < 4'd8) ? cur[4 + 3'(3'd7 - bit_idx[2:0])] : !act.ack_drive;
  assign in_bit    = spi_q ? miso_i : sda_i;
  assign ack_now   = (ph_q == PH_BIT) ? !sda_i : ack_low_q;
  assign last_slot = (slot_q == IW'(NSLOT - 1));
  assign busy_o    = (ph_q != PH_IDLE);
  assign done_o    = (ph_q == PH_FIN);
  assign slot_rd_o = rd_q;

  cmd_decode u_dec (
    .spi_i(spi_q), .icom_i(cur[15:12]), .fcom_i(cur[3:0]),
    .act_o(act), .npre_o(npre), .nbit_o(nbit), .npost_o(npost)
  );

  rb_encode u_rb (
    .spi_i(spi_q), .pre_i(act.pre), .fcom_i(cur[3:0]),
    .sda_first_i(sda_first_q), .ack_low_i(ack_now), .rx_i(rx_q), .rd_o(rb)
  );

  step_timer #(.HALF(HALF)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(ph_q == PH_PRE || ph_q == PH_BIT || ph_q == PH_POST),
    .last_o(t_last)
  );

  always_comb begin
    case (ph_q)
      PH_PRE:  step_end = 5'(npre) - 5'd1;
      PH_POST: step_end = 5'(npost) - 5'd1;
      default: step_end = nbit - 5'd1;
    endcase
  end

  // line levels: steps set them, other phases hold
  always_comb begin
    scl_oe_o = scl_h; sda_oe_o = sda_h; sck_o = sck_h; mosi_o = mosi_h; csn_o = csn_h;
    case (ph_q)
      PH_PRE: begin
        if (spi_q) begin
          csn_o = 1'b1; sck_o = 1'b0;
        end else if (act.pre == PRE_START) begin
          scl_oe_o = (step_q == 5'd0); sda_oe_o = (step_q == 5'd2);
        end else begin
          scl_oe_o = (step_q == 5'd0); sda_oe_o = (step_q != 5'd2);
        end
      end
      PH_BIT: begin
        if (spi_q) begin
          sck_o = hi; mosi_o = cur_bit; csn_o = 1'b0;
        end else begin
          scl_oe_o = !hi; sda_oe_o = !cur_bit;
        end
      end
      PH_POST: begin
        if (spi_q) begin
          sck_o = 1'b0; csn_o = act.post_stop;
        end else begin
          scl_oe_o = (step_q == 5'd0); sda_oe_o = (step_q != 5'd2);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_h <= 1'b0; sda_h <= 1'b0; sck_h <= 1'b0; mosi_h <= 1'b0; csn_h <= 1'b1;
    end else begin
      scl_h <= scl_oe_o; sda_h <= sda_oe_o; sck_h <= sck_o; mosi_h <= mosi_o; csn_h <= csn_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE; slot_q <= '0; step_q <= '0; spi_q <= 1'b0;
      wr_q <= '0; rd_q <= '0; rx_q <= '0; sda_first_q <= 1'b0; ack_low_q <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start_i) begin
          wr_q <= slot_wr_i; spi_q <= mode_spi_i; slot_q <= '0; ph_q <= PH_LOAD;
        end
        PH_LOAD: begin
          sda_first_q <= sda_i;
          step_q      <= '0;
          if (act.skip) begin
            rd_q[slot_q] <= cur;
            if (last_slot) ph_q <= PH_FIN;
            else slot_q <= slot_q + 1'b1;
          end else begin
            ph_q <= (npre != 2'd0) ? PH_PRE : PH_BIT;
          end
        end
        PH_PRE: if (t_last) begin
          if (step_q == step_end) begin step_q <= '0; ph_q <= PH_BIT; end
          else step_q <= step_q + 5'd1;
        end
        PH_BIT: if (t_last) begin
          if (hi && bit_idx < 4'd8) rx_q <= {rx_q[6:0], in_bit};
          else if (hi)              ack_low_q <= !sda_i;
          if (step_q == step_end) begin
            step_q <= '0;
            if (npost != 2'd0) ph_q <= PH_POST;
            else begin
              rd_q[slot_q] <= rb;
              if (last_slot) ph_q <= PH_FIN;
              else begin slot_q <= slot_q + 1'b1; ph_q <= PH_LOAD; end
            end
          end else step_q <= step_q + 5'd1;
        end
        PH_POST: if (t_last) begin
          if (step_q == step_end) begin
            rd_q[slot_q] <= rb;
            if (last_slot) ph_q <= PH_FIN;
            else begin slot_q <= slot_q + 1'b1; ph_q <= PH_LOAD; end
          end else step_q <= step_q + 5'd1;
        end
        PH_FIN:  ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  a_r2_sda_still_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_BIT && !spi_q && !scl_oe_o && hi) |-> $stable(sda_oe_o));
  a_r6_sck_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !csn_o);
  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_done_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
endmodule

// File: tb/cmd_serial_master_tb.sv
`timescale 1ns/1ps
module cmd_serial_master_tb_top;
  localparam int NSLOT = 3;
  localparam int HALF  = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_spi = 1'b0;
  logic [NSLOT*16-1:0] slot_wr = '0;
  logic [NSLOT*16-1:0] slot_rd;
  logic busy, done, scl_oe, sda_oe, sck, mosi, csn;
  logic pull = 1'b0, miso = 1'b0;
  logic sda;

  always #2.5 clk = ~clk;
  assign sda = ~(sda_oe | pull);

  cmd_serial_master #(.NSLOT(NSLOT), .HALF(HALF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_spi_i(mode_spi),
    .slot_wr_i(slot_wr), .busy_o(busy), .done_o(done), .slot_rd_o(slot_rd),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda),
    .sck_o(sck), .mosi_o(mosi), .csn_o(csn), .miso_i(miso)
  );

  int total = 0, bad = 0;
  logic [6:0] q_exp[$];
  logic q_pull[$], q_miso[$], q_fin[$];
  logic m_scl, m_sda, m_sck, m_mosi, m_csn;
  logic [15:0] wr[NSLOT], exp_rd[NSLOT];
  logic [7:0] spull[NSLOT], miso_b[NSLOT];
  logic sack[NSLOT], lpull[NSLOT];
  string rd_tag[NSLOT];

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(input int n, input logic p, input logic mi, input logic fin, input logic bz);
    for (int i = 0; i < n; i++) begin
      q_exp.push_back({m_scl, m_sda, m_sck, m_mosi, m_csn, bz, fin});
      q_pull.push_back(p); q_miso.push_back(mi); q_fin.push_back(fin);
    end
  endtask

  task automatic stop_seq();
    m_scl = 1; m_sda = 1; push(HALF, 0, 0, 0, 1);
    m_scl = 0;            push(HALF, 0, 0, 0, 1);
    m_sda = 0;            push(HALF, 0, 0, 0, 1);
  endtask

  task automatic build(input logic spi);
    for (int s = 0; s < NSLOT; s++) begin
      logic [3:0] ic, fc, ini, fin;
      logic [7:0] d, rx;
      logic first, line, ackl;
      ic = wr[s][15:12]; d = wr[s][11:4]; fc = wr[s][3:0];
      push(1, lpull[s], 0, 0, 1);
      first = !(m_sda || lpull[s]);
      if ((spi && ic == 4'hF) || (!spi && ic == 4'h7)) begin
        exp_rd[s] = wr[s]; rd_tag[s] = "R9 skip";
        continue;
      end
      if (!spi) begin
        rd_tag[s] = "R4 R5 i2c readback";
        if (ic == 4'h6) begin
          m_scl = 1; m_sda = 0; push(HALF, 0, 0, 0, 1);
          m_scl = 0;            push(HALF, 0, 0, 0, 1);
          m_sda = 1;            push(HALF, 0, 0, 0, 1);
          ini = 4'h6;
        end else if (ic == 4'h1) begin
          stop_seq(); ini = 4'h1;
        end else ini = first ? 4'h7 : 4'h0;
        rx = 0; ackl = 0;
        for (int k = 0; k < 9; k++) begin
          logic b, pl;
          b  = (k < 8) ? d[7-k] : (fc != 4'h0);
          pl = (k < 8) ? spull[s][7-k] : sack[s];
          m_scl = 1; m_sda = !b; push(HALF, pl, 0, 0, 1);
          m_scl = 0;             push(HALF, pl, 0, 0, 1);
          line = !(m_sda || pl);
          if (k < 8) rx = {rx[6:0], line}; else ackl = !line;
        end
        if (fc == 4'h9) stop_seq();
        if (fc == 4'h0)      fin = 4'h0;
        else if (fc == 4'h9) fin = ackl ? 4'h1 : 4'h9;
        else                 fin = ackl ? 4'h7 : 4'hF;
        exp_rd[s] = {ini, rx, fin};
      end else begin
        rd_tag[s] = "R8 spi readback";
        if (ic == 4'h9) begin m_csn = 1; m_sck = 0; push(HALF, 0, 0, 0, 1); end
        for (int k = 0; k < 8; k++) begin
          m_csn = 0; m_mosi = d[7-k];
          m_sck = 0; push(HALF, 0, miso_b[s][7-k], 0, 1);
          m_sck = 1; push(HALF, 0, miso_b[s][7-k], 0, 1);
        end
        m_sck = 0; m_csn = (fc == 4'h9); push(HALF, 0, 0, 0, 1);
        exp_rd[s] = {4'h7, miso_b[s], 4'hF};
      end
    end
    push(1, 0, 0, 1, 1);
    push(1, 0, 0, 0, 0);
  endtask

  task automatic run(input logic spi, input logic stray);
    int idx;
    build(spi);
    @(negedge clk);
    mode_spi = spi; slot_wr = {wr[2], wr[1], wr[0]}; start = 1;
    @(negedge clk);
    idx = 0;
    while (q_exp.size() > 0) begin
      logic [6:0] e;
      logic f;
      e = q_exp.pop_front(); pull = q_pull.pop_front();
      miso = q_miso.pop_front(); f = q_fin.pop_front();
      start = (stray && idx == 4);
      chk(spi ? "R6 R7 R10 spi pins" : "R1 R2 R3 R10 i2c pins",
          48'({scl_oe, sda_oe, sck, mosi, csn, busy, done}), 48'(e));
      if (f) for (int s = 0; s < NSLOT; s++)
        chk(rd_tag[s], 48'(slot_rd[s*16 +: 16]), 48'(exp_rd[s]));
      idx++;
      @(negedge clk);
    end
    start = 0; pull = 0; miso = 0;
    if (stray) chk("R10 stray start ignored", 48'(busy), 48'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_scl = 0; m_sda = 0; m_sck = 0; m_mosi = 0; m_csn = 1;
    repeat (3) @(negedge clk);
    chk("R11 reset pins", 48'({scl_oe, sda_oe, sck, mosi, csn, busy, done}), 48'(7'b0000100));
    chk("R11 reset readback", 48'(slot_rd), 48'(0));
    rst_n = 1;
    // I2C: start + slave ack, blank low with slave NACK, blank high + NACK-stop
    wr[0] = 16'h6900; spull[0] = 8'h00; sack[0] = 1; lpull[0] = 0;
    wr[0][3:0] = 4'h8;
    wr[1] = {4'h0, 8'h3C, 4'h8}; spull[1] = 8'h00; sack[1] = 0; lpull[1] = 1;
    wr[2] = {4'h0, 8'hFF, 4'h9}; spull[2] = 8'h0F; sack[2] = 0; lpull[2] = 0;
    run(0, 0);
    // I2C: skip, leading stop + master ack, start + ack-stop
    wr[0] = {4'h7, 8'hAA, 4'h3}; spull[0] = 0; sack[0] = 0; lpull[0] = 0;
    wr[1] = {4'h1, 8'h12, 4'h0}; spull[1] = 0; sack[1] = 0; lpull[1] = 0;
    wr[2] = {4'h6, 8'h81, 4'h9}; spull[2] = 0; sack[2] = 1; lpull[2] = 0;
    run(0, 0);
    // SPI: deselect first, release after, skip; stray start mid-run
    wr[0] = {4'h9, 8'hC3, 4'h8}; miso_b[0] = 8'h5A; lpull[0] = 0;
    wr[1] = {4'h8, 8'h01, 4'h9}; miso_b[1] = 8'hFF;
    wr[2] = {4'hF, 8'h77, 4'h1}; miso_b[2] = 8'h00;
    run(1, 1);
    // SPI: chip select held low, two keep-low trailing codes
    wr[0] = {4'h8, 8'h7E, 4'h8}; miso_b[0] = 8'h81;
    wr[1] = {4'h8, 8'h00, 4'h0}; miso_b[1] = 8'h3C;
    wr[2] = {4'h8, 8'h80, 4'h9}; miso_b[2] = 8'hC0;
    run(1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule